// File: doc/BRIEF.md
# Ring-Oscillator Raw Entropy Collector

This block gathers raw bits from a bank of free-running oscillators and stores them as 64-bit words in an on-chip queue that a consumer drains through a simple read port. The oscillator bank appears as a 128-bit input bus that is sampled on every clock. A group field picks which eight oscillators are observed. Over eight cycles, eight consecutive samples of those eight oscillators are packed into one word, and that word is pushed into the queue.

When raw exposure is off, or when the oscillator source is disabled, the oscillator path is shut off. Words then come from an external conditioner port. A latency counter accepts one conditioner word every 81 cycles, and a pulse on `cond_ack` tells the conditioner that its word was taken.

Control is a single write port with enable, source-enable, raw-exposure and group fields, plus two self-clearing reset bits. Status shows the fill level and a sticky underflow flag. Generation stops while the queue is full. It starts again as soon as a read frees a slot.

Top module: `rosc_entropy_fifo`

## Requirements
- R1: After `rst_n` is released, `stat_level` is 0, `stat_underflow` is 0, `rd_data` is 0 and the engine is disabled, so no words appear however long the block waits.
- R2: Control word layout: bit0 enable, bit1 source-enable, bit2 raw-exposure, bit3 generator reset, bit4 queue reset, bits[8:5] group g. In raw mode (bits 0, 1 and 2 all set), each word has bit [8*s+r] = sample s (0 is oldest) of `osc_i[8*g+r]`.
- R3: In raw mode, the first sample is taken at the clock edge after the control write. A word is pushed on every eighth sampling edge, so the level rises from 0 to 1 exactly eight edges after the write.
- R4: A control write that changes the group, raw-exposure, enable or source-enable bit throws away any partly built word. It takes no sample on its own edge, and the next word holds only the eight samples that follow.
- R5: With enable and source-enable set and raw-exposure clear, `cond_data` is taken into the queue on the 81st edge after the control write. `cond_ack` is high during the cycle before that edge.
- R6: With enable set and source-enable clear, the oscillator path is off even if raw-exposure is set. Only conditioner words enter, with the same 81-cycle latency.
- R7: The queue holds 64 words and returns them in the order they were written. When it is full, sampling stops and no word is dropped or overwritten.
- R8: A read from a full queue lowers the level to 63, and generation resumes. In raw mode the level returns to 64 eight edges later.
- R9: A read while the level is 0 returns `rd_data` = 0 and sets `stat_underflow`. The flag stays set until a reset bit is written.
- R10: A control write with bit3 or bit4 set empties the queue, clears the underflow flag and clears all control fields, which disables the engine.
- R11: Clearing the enable bit stops generation but keeps the words already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_i | input | 128 | Oscillator sample bus, one bit per oscillator |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 9 | Control word (layout in R2) |
| cond_data | input | 64 | Word offered by the external conditioner |
| cond_ack | output | 1 | High in the cycle the conditioner word is taken |
| rd_en | input | 1 | Pop request |
| rd_data | output | 64 | Popped word, valid the cycle after `rd_en` |
| stat_level | output | 7 | Number of words held, 0 to 64 |
| stat_underflow | output | 1 | Sticky flag for a read of an empty queue |

## Verification
Raw packing is driven with an oscillator pattern that changes on every cycle and differs in every byte lane. This tells apart a swapped sample index, a swapped oscillator index and a wrong group offset. It is run on group 0 and group 15 to cover both ends of the select range. A group change in the middle of a word uses samples that differ before and after the change, so a word that kept stale samples stands out. In the two conditioner modes, a toggling oscillator input is held beside a fixed `cond_data` value, which shows whether any oscillator bits leak in. The queue is then filled past its capacity with a continuous sample stream, so a dropped, overwritten or misordered word breaks the expected sequence.

// File: rtl/rosc_entropy_fifo.sv
module rosc_entropy_fifo #(
  parameter int N_OSC    = 128,
  parameter int GROUP    = 8,
  parameter int DEPTH    = 64,
  parameter int COND_LAT = 81
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_OSC-1:0]             osc_i,
  input  logic                         ctl_we,
  input  logic [5+$clog2(N_OSC/GROUP)-1:0] ctl_wdata,
  input  logic [GROUP*GROUP-1:0]       cond_data,
  output logic                         cond_ack,
  input  logic                         rd_en,
  output logic [GROUP*GROUP-1:0]       rd_data,
  output logic [$clog2(DEPTH):0]       stat_level,
  output logic                         stat_underflow
);
  localparam int WORD_W = GROUP * GROUP;
  localparam int NGRP   = N_OSC / GROUP;
  localparam int GSEL_W = $clog2(NGRP);
  localparam int AW     = $clog2(DEPTH);
  localparam int LW     = AW + 1;
  localparam int SW     = $clog2(GROUP);
  localparam int CW     = $clog2(COND_LAT);
  localparam int ASM_W  = WORD_W - GROUP;

  logic              en_q, ent_q, raw_q;
  logic [GSEL_W-1:0] grp_q;
  logic [SW-1:0]     scnt;
  logic [CW-1:0]     ccnt;
  logic [ASM_W-1:0]  asm_q;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [LW-1:0]     level;

  wire [GSEL_W-1:0] w_grp = ctl_wdata[5 +: GSEL_W];
  wire wr_rst   = ctl_we & (ctl_wdata[3] | ctl_wdata[4]);
  wire restart  = ctl_we & ((w_grp != grp_q) | (ctl_wdata[0] != en_q) |
                            (ctl_wdata[1] != ent_q) | (ctl_wdata[2] != raw_q));
  wire hold     = wr_rst | restart;
  wire full     = (level == LW'(DEPTH));
  wire empty    = (level == '0);
  wire raw_mode = en_q & ent_q & raw_q;
  wire cnd_mode = en_q & ~raw_mode;

  wire [GROUP-1:0] sel = osc_i[grp_q*GROUP +: GROUP];

  wire raw_step = raw_mode & ~full & ~hold;
  wire raw_push = raw_step & (scnt == SW'(GROUP-1));
  wire cnd_step = cnd_mode & ~full & ~hold;
  wire cnd_push = cnd_step & (ccnt == CW'(COND_LAT-1));
  wire push     = raw_push | cnd_push;
  wire pop      = rd_en & ~empty & ~wr_rst;
  wire [WORD_W-1:0] push_data = raw_push ? {sel, asm_q} : cond_data;

  assign cond_ack       = cnd_push;
  assign stat_level     = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ent_q <= 1'b0;
      raw_q <= 1'b0;
      grp_q <= '0;
    end else if (wr_rst) begin
      en_q  <= 1'b0;
      ent_q <= 1'b0;
      raw_q <= 1'b0;
      grp_q <= '0;
    end else if (ctl_we) begin
      en_q  <= ctl_wdata[0];
      ent_q <= ctl_wdata[1];
      raw_q <= ctl_wdata[2];
      grp_q <= w_grp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt  <= '0;
      ccnt  <= '0;
      asm_q <= '0;
    end else begin
      if (hold || !raw_mode) scnt <= '0;
      else if (raw_step) begin
        scnt  <= scnt + SW'(1);
        asm_q <= {sel, asm_q[ASM_W-1:GROUP]};
      end
      if (hold || !cnd_mode) ccnt <= '0;
      else if (cnd_step) ccnt <= cnd_push ? '0 : ccnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !wr_rst) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr           <= '0;
      rptr           <= '0;
      level          <= '0;
      rd_data        <= '0;
      stat_underflow <= 1'b0;
    end else if (wr_rst) begin
      wptr           <= '0;
      rptr           <= '0;
      level          <= '0;
      rd_data        <= '0;
      stat_underflow <= 1'b0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      level <= level + LW'(push) - LW'(pop);
      if (rd_en) begin
        rd_data <= empty ? '0 : mem[rptr];
        if (empty) stat_underflow <= 1'b1;
      end
    end
  end

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_level <= LW'(DEPTH));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en && !wr_rst) |=> stat_level == LW'(DEPTH));

  // R9
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_rst) |=> (rd_data == '0) && stat_underflow);

  // R9
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_underflow && !wr_rst) |=> stat_underflow);

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (stat_level == '0) && !stat_underflow && !cond_ack);

  // R6
  push_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && !pop && !raw_mode && !cond_ack) |=> stat_level == $past(stat_level));
endmodule

// File: tb/sim_rosc_entropy_fifo.sv
module sim_rosc_entropy_fifo;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] osc_i = '0;
  logic         ctl_we = 1'b0;
  logic [8:0]   ctl_wdata = '0;
  logic [63:0]  cond_data = '0;
  logic         cond_ack;
  logic         rd_en = 1'b0;
  logic [63:0]  rd_data;
  logic [6:0]   stat_level;
  logic         stat_underflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rosc_entropy_fifo u0 (
    .clk(clk), .rst_n(rst_n), .osc_i(osc_i), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cond_data(cond_data), .cond_ack(cond_ack), .rd_en(rd_en), .rd_data(rd_data),
    .stat_level(stat_level), .stat_underflow(stat_underflow));

  function automatic logic [127:0] pat(int k);
    logic [31:0] kk = 32'(k);
    return {kk * 32'h9E3779B1, (kk * 32'h85EBCA6B) ^ 32'h0000_1234,
            kk * 32'hC2B2AE35, kk * 32'd7 + 32'hDEAD_0000};
  endfunction

  function automatic logic [63:0] raw_word(int g, int k0);
    logic [63:0] w;
    logic [127:0] p;
    for (int s = 0; s < 8; s++) begin
      p = pat(k0 + s);
      w[8*s +: 8] = p[8*g +: 8];
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input bit en, input bit ent, input bit raw, input int g, input bit grst, input bit frst);
    ctl_we = 1'b1;
    ctl_wdata = {4'(g), frst, grst, raw, ent, en};
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic drive(input int k0, input int n);
    for (int i = 0; i < n; i++) begin
      osc_i = pat(k0 + i);
      @(negedge clk);
    end
  endtask

  task automatic pop_word(output logic [63:0] w);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    w = rd_data;
  endtask

  task automatic t_reset_state;
    chk(stat_level == 0, "R1 level", 64'(stat_level), 0);
    chk(stat_underflow == 0, "R1 underflow", 64'(stat_underflow), 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
    drive(1, 100);
    chk(stat_level == 0, "R1 idle engine", 64'(stat_level), 0);
  endtask

  task automatic t_raw(input int g, input int k0);
    logic [63:0] w;
    wr_ctl(0, 0, 0, 0, 1, 0);
    wr_ctl(1, 1, 1, g, 0, 0);
    drive(k0, 7);
    chk(stat_level == 0, "R3 no word after 7", 64'(stat_level), 0);
    drive(k0 + 7, 1);
    chk(stat_level == 1, "R3 word after 8", 64'(stat_level), 1);
    wr_ctl(0, 1, 1, g, 0, 0);
    pop_word(w);
    chk(w == raw_word(g, k0), "R2 raw packing", w, raw_word(g, k0));
  endtask

  task automatic t_regroup;
    logic [63:0] w;
    wr_ctl(0, 0, 0, 0, 0, 1);
    wr_ctl(1, 1, 1, 2, 0, 0);
    drive(300, 3);
    osc_i = pat(399);
    wr_ctl(1, 1, 1, 5, 0, 0);
    drive(400, 7);
    chk(stat_level == 0, "R4 restart count", 64'(stat_level), 0);
    drive(407, 1);
    chk(stat_level == 1, "R4 word after restart", 64'(stat_level), 1);
    wr_ctl(1, 1, 0, 5, 0, 0);
    pop_word(w);
    chk(w == raw_word(5, 400), "R4 fresh samples only", w, raw_word(5, 400));
  endtask

  task automatic t_cond(input bit ent, input logic [63:0] val, input string tag);
    logic [63:0] w;
    wr_ctl(0, 0, 0, 0, 1, 0);
    cond_data = val;
    wr_ctl(1, ent, !ent, 3, 0, 0);
    drive(500, 80);
    chk(stat_level == 0, {tag, " none before 81"}, 64'(stat_level), 0);
    chk(cond_ack == 1, {tag, " ack in cycle 81"}, 64'(cond_ack), 1);
    drive(580, 1);
    chk(stat_level == 1, {tag, " word at 81"}, 64'(stat_level), 1);
    wr_ctl(0, 0, 0, 0, 0, 0);
    pop_word(w);
    chk(w == val, {tag, " conditioner data"}, w, val);
  endtask

  task automatic t_full;
    logic [63:0] w;
    wr_ctl(0, 0, 0, 0, 0, 1);
    wr_ctl(1, 1, 1, 9, 0, 0);
    drive(1000, 512 + 20);
    chk(stat_level == 64, "R7 full level", 64'(stat_level), 64);
    pop_word(w);
    chk(w == raw_word(9, 1000), "R7 first word", w, raw_word(9, 1000));
    chk(stat_level == 63, "R8 level after read", 64'(stat_level), 63);
    drive(3000, 7);
    chk(stat_level == 63, "R8 refill timing", 64'(stat_level), 63);
    drive(3007, 1);
    chk(stat_level == 64, "R8 refilled", 64'(stat_level), 64);
    wr_ctl(0, 1, 1, 9, 0, 0);
    drive(4000, 20);
    chk(stat_level == 64, "R11 disable keeps words", 64'(stat_level), 64);
    begin
      int bad = 0;
      for (int j = 1; j < 64; j++) begin
        pop_word(w);
        if (w != raw_word(9, 1000 + 8*j)) begin
          bad++;
          chk(0, "R7 order", w, raw_word(9, 1000 + 8*j));
        end
      end
      chk(bad == 0, "R7 no drop or overwrite", 64'(bad), 0);
    end
    pop_word(w);
    chk(w == raw_word(9, 3000), "R8 refill word", w, raw_word(9, 3000));
    chk(stat_level == 0, "R7 drained", 64'(stat_level), 0);
  endtask

  task automatic t_underflow;
    logic [63:0] w;
    wr_ctl(0, 0, 0, 0, 1, 0);
    pop_word(w);
    chk(w == 0, "R9 empty read zero", w, 0);
    chk(stat_underflow == 1, "R9 underflow set", 64'(stat_underflow), 1);
    wr_ctl(1, 1, 1, 0, 0, 0);
    drive(5000, 16);
    chk(stat_underflow == 1, "R9 sticky", 64'(stat_underflow), 1);
    chk(stat_level == 2, "R9 level before reset", 64'(stat_level), 2);
    wr_ctl(1, 1, 1, 0, 0, 1);
    chk(stat_level == 0 && stat_underflow == 0, "R10 reset clears",
        {stat_underflow, 57'(0), stat_level}, 0);
    drive(6000, 20);
    chk(stat_level == 0, "R10 engine disabled", 64'(stat_level), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_raw(0, 10);
    t_raw(15, 50);
    t_regroup();
    t_cond(1'b1, 64'hA5A5_0F0F_1234_5678, "R5");
    t_cond(1'b0, 64'h0123_4567_89AB_CDEF, "R6");
    t_full();
    t_underflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule